// File: doc/BRIEF.md
# Baseline-Corrected Pulse Trigger

This block sits at the front of one detector channel and takes one signed 12-bit converter sample on every clock. It keeps a running estimate of the channel's DC level and of its noise spread, learned from the signal itself while the channel is quiet. It subtracts the DC estimate from every sample and streams the corrected value out. A pulse trigger is raised when two accepted samples in a row both exceed the learned noise threshold plus a configurable margin.

When a pulse is declared, the block emits a one-cycle trigger strobe together with the index of the first qualifying sample. It then sums the corrected samples over a configurable window that begins with that first sample, and presents the sum as the pulse energy. While a pulse is in progress the estimators are frozen, and re-triggering is held off until the window has closed and the signal has settled.

The input stream cannot be stalled: `s_ready` is always high and a sample is taken in every cycle where `s_valid` is high. The corrected output stream has no back-pressure. `m_valid` follows `s_valid` with one cycle of latency, and a consumer must take each output in the cycle it is presented.

Top module: `pulse_trigger`

## Requirements
- R1: `s_ready` is always 1, and `m_valid` is high exactly in the cycle after each accepted sample. After reset, `m_valid`, `trig`, `energy_valid` and `busy` are 0.
- R2: The first sample accepted after reset sets the baseline to that sample exactly, and its corrected output is 0. Every later corrected output `m_data` equals the sample minus the current baseline, as a 13-bit signed value, one cycle after acceptance.
- R3: On each quiet sample, the baseline follows a power-of-two moving average with K=4: `acc += sample - baseline`, and `baseline = acc >>> K`, where `acc` holds the baseline scaled by 2^K. With a steady input the corrected output therefore decays to 0.
- R4: A sample is quiet only when the block is not busy and its corrected value does not exceed the threshold. A sample that is not quiet changes neither the baseline nor the noise estimate.
- R5: The noise estimate is the same K=4 moving average, applied to the absolute corrected value on quiet samples. The threshold is `noise * cfg_mult + cfg_margin`, and a sample counts as above threshold only when its corrected value is strictly greater than the threshold.
- R6: While not busy, `trig` pulses high for one cycle, in the cycle after the second of two consecutive accepted samples that are both above threshold. A lone above-threshold sample gives no trigger, and neither does a sample equal to the threshold. Cycles with `s_valid` low do not break a pair.
- R7: With each trigger, `trig_time` gives the index of the first sample of the qualifying pair. Accepted samples are numbered from 0 after reset, and cycles with `s_valid` low are not counted.
- R8: `energy` is the sum of the corrected values of N accepted samples, starting with the first sample of the pair. N is `cfg_win_len`, and values below 2 are treated as 2. `energy_valid` pulses for one cycle, in the cycle after the Nth sample; with N=2 this is the same cycle as `trig`.
- R9: From the trigger onward `busy` is 1 and no new trigger can fire. `busy` returns to 0 only after the window has closed and two consecutive accepted samples are not above threshold. An above-threshold sample during this settling phase restarts the count of two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Input sample present this cycle |
| s_ready | output | 1 | Always 1; the input is never stalled |
| s_data | input | 12 | Signed converter sample |
| cfg_margin | input | 12 | Fixed margin added to the threshold (unsigned) |
| cfg_mult | input | 4 | Multiplier applied to the noise estimate |
| cfg_win_len | input | 8 | Energy window length in samples (minimum 2) |
| m_valid | output | 1 | Corrected sample present |
| m_data | output | 13 | Signed baseline-corrected sample |
| trig | output | 1 | One-cycle pulse trigger strobe |
| trig_time | output | 32 | Index of the first qualifying sample |
| energy_valid | output | 1 | One-cycle strobe marking a finished energy sum |
| energy | output | 21 | Signed energy sum of the window |
| busy | output | 1 | A pulse is in its window or settling phase |

## Verification
The main function is exercised with several input patterns, each chosen to separate a correct design from a specific fault:
- A small step on a seeded baseline: its exact decay sequence separates the averaging weight from other weights and from no tracking at all.
- A lone spike followed by a quiet sample: shows whether above-threshold samples leak into the baseline.
- A sample equal to the threshold: separates a strict comparison from an inclusive one.
- A pair split by idle cycles: shows that only accepted samples count, both for pairing and for the timestamp.
- Zero-mean alternating noise, followed by pulses under different multipliers: shows that the threshold really scales with the learned noise.
- A pulse that stays high after its window, with a brief dip: separates the two-sample settling rule from early re-arming.

// File: rtl/ptrig_pkg.sv
package ptrig_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_WINDOW = 2'd1,
    ST_SETTLE = 2'd2
  } ptrig_state_e;
endpackage

// File: rtl/ptrig_tracker.sv
module ptrig_tracker #(
  parameter int SAMPLE_W = 12,
  parameter int K        = 4,
  parameter int MULT_W   = 4,
  localparam int CORR_W  = SAMPLE_W + 1,
  localparam int ACC_W   = SAMPLE_W + K + 2,
  localparam int THR_W   = SAMPLE_W + MULT_W + 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  input  logic signed [SAMPLE_W-1:0] sample,
  input  logic signed [CORR_W-1:0]   corr,
  input  logic                       quiet,
  input  logic [SAMPLE_W-1:0]        cfg_margin,
  input  logic [MULT_W-1:0]          cfg_mult,
  output logic                       seeded,
  output logic signed [SAMPLE_W-1:0] baseline,
  output logic [THR_W-1:0]           threshold
);
  logic signed [ACC_W-1:0] base_acc;
  logic signed [ACC_W-1:0] dev_acc;
  logic signed [ACC_W-1:0] sample_x;
  logic signed [ACC_W-1:0] base_x;
  logic signed [ACC_W-1:0] mag_x;
  logic signed [ACC_W-1:0] dev_x;
  logic [SAMPLE_W-1:0]     noise;

  assign baseline = base_acc[K +: SAMPLE_W];
  assign noise    = dev_acc[K +: SAMPLE_W];
  assign sample_x = ACC_W'(sample);
  assign base_x   = ACC_W'(baseline);
  assign mag_x    = corr[CORR_W-1] ? -ACC_W'(corr) : ACC_W'(corr);
  assign dev_x    = ACC_W'({1'b0, noise});

  assign threshold = THR_W'(noise) * THR_W'(cfg_mult) + THR_W'(cfg_margin);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seeded   <= 1'b0;
      base_acc <= '0;
      dev_acc  <= '0;
    end else if (in_valid && !seeded) begin
      seeded   <= 1'b1;
      base_acc <= sample_x <<< K;
      dev_acc  <= '0;
    end else if (in_valid && quiet) begin
      base_acc <= base_acc + sample_x - base_x;
      dev_acc  <= dev_acc + mag_x - dev_x;
    end
  end

  // R4: estimators hold still on samples that are not quiet
  a_r4_frozen_when_active: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && seeded && !quiet) |=> ($stable(baseline) && $stable(noise)));

  // R2: seeding happens exactly once after reset
  a_r2_seed_once: assert property (@(posedge clk) disable iff (!rst_n)
    seeded |=> seeded);
endmodule

// File: rtl/ptrig_qualify.sv
module ptrig_qualify
  import ptrig_pkg::*;
#(
  parameter int CORR_W = 13,
  parameter int THR_W  = 17,
  parameter int WIN_W  = 8,
  parameter int TS_W   = 32,
  localparam int EN_W  = CORR_W + WIN_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic signed [CORR_W-1:0] corr,
  input  logic [THR_W-1:0]         threshold,
  input  logic [WIN_W-1:0]         cfg_win_len,
  input  logic [TS_W-1:0]          stamp,
  output logic                     quiet,
  output logic                     trig,
  output logic [TS_W-1:0]          trig_time,
  output logic                     energy_valid,
  output logic signed [EN_W-1:0]   energy,
  output logic                     busy
);
  ptrig_state_e             state;
  logic                     pend;
  logic signed [CORR_W-1:0] pend_corr;
  logic [TS_W-1:0]          pend_stamp;
  logic [WIN_W-1:0]         cnt;
  logic [WIN_W-1:0]         cnt_next;
  logic [WIN_W-1:0]         win_need;
  logic signed [EN_W-1:0]   acc;
  logic signed [EN_W-1:0]   pair_sum;
  logic signed [EN_W-1:0]   win_sum;
  logic                     settle_one;
  logic                     above;
  logic signed [THR_W:0]    thr_s;
  logic signed [THR_W:0]    corr_s;

  assign thr_s    = {1'b0, threshold};
  assign corr_s   = (THR_W + 1)'(corr);
  assign above    = corr_s > thr_s;
  assign quiet    = (state == ST_IDLE) && !above;
  assign busy     = (state != ST_IDLE);
  assign win_need = (cfg_win_len < WIN_W'(2)) ? WIN_W'(2) : cfg_win_len;
  assign cnt_next = cnt + WIN_W'(1);
  assign pair_sum = EN_W'(pend_corr) + EN_W'(corr);
  assign win_sum  = acc + EN_W'(corr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state        <= ST_IDLE;
      pend         <= 1'b0;
      pend_corr    <= '0;
      pend_stamp   <= '0;
      cnt          <= '0;
      acc          <= '0;
      settle_one   <= 1'b0;
      trig         <= 1'b0;
      trig_time    <= '0;
      energy_valid <= 1'b0;
      energy       <= '0;
    end else begin
      trig         <= 1'b0;
      energy_valid <= 1'b0;
      if (in_valid) begin
        case (state)
          ST_IDLE: begin
            if (above && pend) begin
              trig       <= 1'b1;
              trig_time  <= pend_stamp;
              pend       <= 1'b0;
              settle_one <= 1'b0;
              if (win_need == WIN_W'(2)) begin
                energy       <= pair_sum;
                energy_valid <= 1'b1;
                state        <= ST_SETTLE;
              end else begin
                acc   <= pair_sum;
                cnt   <= WIN_W'(2);
                state <= ST_WINDOW;
              end
            end else if (above) begin
              pend       <= 1'b1;
              pend_corr  <= corr;
              pend_stamp <= stamp;
            end else begin
              pend <= 1'b0;
            end
          end
          ST_WINDOW: begin
            cnt <= cnt_next;
            if (cnt_next == win_need) begin
              energy       <= win_sum;
              energy_valid <= 1'b1;
              settle_one   <= 1'b0;
              state        <= ST_SETTLE;
            end else begin
              acc <= win_sum;
            end
          end
          ST_SETTLE: begin
            if (above) begin
              settle_one <= 1'b0;
            end else if (settle_one) begin
              settle_one <= 1'b0;
              state      <= ST_IDLE;
            end else begin
              settle_one <= 1'b1;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  // R6: a trigger follows an accepted sample and lasts one cycle
  a_r6_trig_on_sample: assert property (@(posedge clk) disable iff (!rst_n)
    trig |-> $past(in_valid));
  a_r6_trig_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> !trig);

  // R9: a trigger always leaves the block busy
  a_r9_busy_after_trig: assert property (@(posedge clk) disable iff (!rst_n)
    trig |-> busy);

  // R8: an energy result closes the window and enters settling
  a_r8_energy_then_settle: assert property (@(posedge clk) disable iff (!rst_n)
    energy_valid |-> (state == ST_SETTLE));
endmodule

// File: rtl/pulse_trigger.sv
module pulse_trigger #(
  parameter int SAMPLE_W = 12,
  parameter int K        = 4,
  parameter int MULT_W   = 4,
  parameter int WIN_W    = 8,
  parameter int TS_W     = 32,
  localparam int CORR_W  = SAMPLE_W + 1,
  localparam int THR_W   = SAMPLE_W + MULT_W + 1,
  localparam int EN_W    = CORR_W + WIN_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       s_valid,
  output logic                       s_ready,
  input  logic signed [SAMPLE_W-1:0] s_data,
  input  logic [SAMPLE_W-1:0]        cfg_margin,
  input  logic [MULT_W-1:0]          cfg_mult,
  input  logic [WIN_W-1:0]           cfg_win_len,
  output logic                       m_valid,
  output logic signed [CORR_W-1:0]   m_data,
  output logic                       trig,
  output logic [TS_W-1:0]            trig_time,
  output logic                       energy_valid,
  output logic signed [EN_W-1:0]     energy,
  output logic                       busy
);
  logic                       seeded;
  logic signed [SAMPLE_W-1:0] baseline;
  logic [THR_W-1:0]           threshold;
  logic signed [CORR_W-1:0]   corr;
  logic                       quiet;
  logic [TS_W-1:0]            stamp;

  assign s_ready = 1'b1;
  assign corr    = seeded ? (CORR_W'(s_data) - CORR_W'(baseline)) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stamp   <= '0;
      m_valid <= 1'b0;
      m_data  <= '0;
    end else begin
      m_valid <= s_valid;
      if (s_valid) begin
        stamp  <= stamp + TS_W'(1);
        m_data <= corr;
      end
    end
  end

  ptrig_tracker #(
    .SAMPLE_W(SAMPLE_W),
    .K       (K),
    .MULT_W  (MULT_W)
  ) u_tracker (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (s_valid),
    .sample    (s_data),
    .corr      (corr),
    .quiet     (quiet),
    .cfg_margin(cfg_margin),
    .cfg_mult  (cfg_mult),
    .seeded    (seeded),
    .baseline  (baseline),
    .threshold (threshold)
  );

  ptrig_qualify #(
    .CORR_W(CORR_W),
    .THR_W (THR_W),
    .WIN_W (WIN_W),
    .TS_W  (TS_W)
  ) u_qualify (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (s_valid),
    .corr        (corr),
    .threshold   (threshold),
    .cfg_win_len (cfg_win_len),
    .stamp       (stamp),
    .quiet       (quiet),
    .trig        (trig),
    .trig_time   (trig_time),
    .energy_valid(energy_valid),
    .energy      (energy),
    .busy        (busy)
  );

  // R1: output stream follows the input stream by one cycle
  a_r1_stream_follow: assert property (@(posedge clk) disable iff (!rst_n)
    s_valid |=> m_valid);
  a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !s_valid |=> !m_valid);

  // R2: the seeding sample comes out as zero
  a_r2_seed_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && !seeded) |=> (m_data == '0));

  // R7: a trigger stamp always names an already accepted sample
  a_r7_stamp_past: assert property (@(posedge clk) disable iff (!rst_n)
    trig |-> (trig_time < stamp));
endmodule

// File: tb/pulse_trigger_bench.sv
`timescale 1ns/100ps
module pulse_trigger_bench;
  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               s_valid = 1'b0;
  logic               s_ready;
  logic signed [11:0] s_data = '0;
  logic [11:0]        cfg_margin = 12'd20;
  logic [3:0]         cfg_mult = 4'd0;
  logic [7:0]         cfg_win_len = 8'd2;
  logic               m_valid;
  logic signed [12:0] m_data;
  logic               trig;
  logic [31:0]        trig_time;
  logic               energy_valid;
  logic signed [20:0] energy;
  logic               busy;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pulse_trigger u_pulse_trigger (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .cfg_margin(cfg_margin), .cfg_mult(cfg_mult),
    .cfg_win_len(cfg_win_len), .m_valid(m_valid), .m_data(m_data),
    .trig(trig), .trig_time(trig_time), .energy_valid(energy_valid),
    .energy(energy), .busy(busy)
  );

  task automatic chk(input string req, input string what,
                     input longint act, input longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    s_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic push(input int x);
    s_valid = 1'b1;
    s_data = 12'(x);
    @(negedge clk);
    s_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    s_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset_state();
    do_reset();
    chk("R1", "s_ready", s_ready, 1);
    chk("R1", "m_valid after reset", m_valid, 0);
    chk("R1", "trig after reset", trig, 0);
    chk("R1", "energy_valid after reset", energy_valid, 0);
    chk("R1", "busy after reset", busy, 0);
    push(7);
    chk("R1", "m_valid after sample", m_valid, 1);
    idle(1);
    chk("R1", "m_valid idle", m_valid, 0);
  endtask

  task automatic t_seed_and_track();
    do_reset();
    cfg_margin = 12'd100; cfg_mult = 4'd0; cfg_win_len = 8'd2;
    push(300);
    chk("R2", "seed sample corrected", m_data, 0);
    push(305);
    chk("R2", "first step corrected", m_data, 5);
    push(305);
    push(305);
    push(305);
    chk("R3", "fourth step corrected", m_data, 5);
    push(305);
    chk("R3", "fifth step corrected", m_data, 4);
    for (int i = 0; i < 200; i++) push(305);
    chk("R3", "settled corrected", m_data, 0);
  endtask

  task automatic t_spike_freeze();
    do_reset();
    cfg_margin = 12'd20; cfg_mult = 4'd0; cfg_win_len = 8'd2;
    push(0);
    push(50);
    chk("R6", "lone spike no trig", trig, 0);
    chk("R2", "spike corrected", m_data, 50);
    push(0);
    chk("R4", "baseline kept after spike", m_data, 0);
    chk("R6", "no trig after lone spike", trig, 0);
    push(20);
    chk("R5", "equal to threshold no trig", trig, 0);
    push(20);
    chk("R5", "equal pair no trig", trig, 0);
  endtask

  task automatic t_short_window_freeze();
    do_reset();
    cfg_margin = 12'd20; cfg_mult = 4'd0; cfg_win_len = 8'd1;
    push(0);
    push(40);
    push(40);
    chk("R6", "pair trig", trig, 1);
    chk("R8", "short window energy_valid", energy_valid, 1);
    chk("R8", "short window energy", energy, 80);
    chk("R9", "busy after trig", busy, 1);
    push(15);
    chk("R9", "busy after one quiet", busy, 1);
    push(15);
    chk("R9", "idle after two quiet", busy, 0);
    push(0);
    chk("R4", "no update while busy", m_data, 0);
  endtask

  task automatic t_pair_window_holdoff();
    do_reset();
    cfg_margin = 12'd20; cfg_mult = 4'd0; cfg_win_len = 8'd4;
    push(0);
    push(0);
    idle(2);
    push(21);
    chk("R6", "first of pair no trig", trig, 0);
    idle(1);
    chk("R6", "idle gap no trig", trig, 0);
    push(25);
    chk("R6", "pair across gap trig", trig, 1);
    chk("R7", "trig_time", trig_time, 2);
    chk("R8", "energy not yet", energy_valid, 0);
    push(10);
    chk("R6", "strobe one cycle", trig, 0);
    chk("R8", "energy not at 3", energy_valid, 0);
    push(5);
    chk("R8", "energy_valid at N", energy_valid, 1);
    chk("R8", "energy sum", energy, 61);
    push(50);
    push(50);
    chk("R9", "no retrigger while high", trig, 0);
    push(0);
    push(50);
    push(0);
    chk("R9", "busy after dip restart", busy, 1);
    push(0);
    chk("R9", "idle after settle", busy, 0);
    push(30);
    push(40);
    chk("R9", "re-armed trig", trig, 1);
    chk("R7", "trig_time after rearm", trig_time, 12);
    chk("R2", "corrected high sample", m_data, 40);
  endtask

  task automatic t_noise_multiplier();
    do_reset();
    cfg_margin = 12'd10; cfg_mult = 4'd1; cfg_win_len = 8'd2;
    push(0);
    for (int i = 0; i < 300; i++) push(((i % 2) == 0) ? 8 : -8);
    chk("R5", "noise quiet no trig", trig, 0);
    push(30);
    push(30);
    chk("R5", "mult 1 trig", trig, 1);
    chk("R8", "mult 1 energy", energy, 60);
    push(8);
    push(-8);
    chk("R9", "settled after noise", busy, 0);
    cfg_mult = 4'd3;
    push(30);
    push(30);
    chk("R5", "mult 3 suppresses trig", trig, 0);
  endtask

  initial begin
    t_reset_state();
    t_seed_and_track();
    t_spike_freeze();
    t_short_window_freeze();
    t_pair_window_holdoff();
    t_noise_multiplier();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule